// File: doc/BRIEF.md
# Programmable Event Counter Unit

This block holds two programmable 40-bit event counters for performance monitoring. On every clock, a multi-lane event bus presents a small count (0 to 3) of occurrences for each monitored event. Each counter has its own configuration word. The word picks one lane using an event code and a unit mask. It also sets the privilege levels that may count, and qualifies the per-cycle count with a threshold comparator, an invert option and a rising-edge mode.

Software writes and reads the configuration words, the counter halves and an overflow status word through a simple synchronous register port. Read data is registered. A counter that wraps past its maximum value sets a sticky overflow flag. With the counter's interrupt enable set, that flag raises an interrupt request, which stays high until software clears the flag. A few event codes are tied to one counter only, and such an event placed on the other counter never counts.

Top module: `evc_unit`

## Requirements
- R1: After a synchronous reset, both counters, both configuration words and both overflow flags read as zero, and `irq` is low.
- R2: The lane index is formed from unit-mask bits 1:0 (upper two bits) and event-code bits 1:0 (lower two bits). Lane k occupies `ev_bus[2k+1:2k]`. With enable (config bit 29) set, threshold zero and edge mode off, the counter adds that lane's value every cycle.
- R3: With a nonzero threshold (config bits 23:16) and invert clear, the counter adds exactly 1 in cycles where the lane value is greater than or equal to the threshold, and 0 otherwise.
- R4: With a nonzero threshold and invert (bit 24) set, the counter adds 1 only in cycles where the lane value is below the threshold. With threshold zero, invert has no effect.
- R5: In edge mode (bit 25), the counter adds 1 only in a cycle where the qualified condition is true and was false in the previous cycle. With threshold zero, the condition is "lane value nonzero".
- R6: Privilege 0 counts only when the OS bit (bit 26) is set. Any nonzero privilege counts only when the user bit (bit 27) is set.
- R7: Event codes 0x14 and 0xC1 count only on counter 0, and event codes 0x13 and 0x11 count only on counter 1. On the other counter they never count.
- R8: Writing address 2/3 (counter 0 low 32 bits / high 8 bits) or 4/5 (counter 1) replaces that part of the counter. In that cycle the write wins over any increment.
- R9: An increment that carries out of bit 39 wraps the counter and sets that counter's sticky overflow flag. The flags read at address 6 (bit 0 for counter 0, bit 1 for counter 1). Writing 1 to a flag's bit clears it, and a new overflow in the same cycle wins over the clear.
- R10: `irq` goes high one cycle after any overflow flag is set whose counter has its interrupt enable (bit 28) set. It stays high until that flag is cleared or the enable is removed.
- R11: Writing a configuration word (address 0 or 1) resets that counter's edge history to "condition false". The register takes the new word at that edge.
- R12: `reg_rdata` shows, one cycle later, the word addressed in the cycle before: 0/1 configuration, 2..5 counter halves, 6 status, 7 zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_bus | input | LANES*EV_W (32) | Per-cycle event counts, one field per lane |
| priv | input | 2 | Current privilege level, 0 is OS |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Overflow interrupt request |

## Verification
Uniformly random lane values in raw mode show whether the correct lane and its full 0..3 weight are summed. The same random traffic under threshold and inverted threshold separates the `>=` comparison from the `<` comparison. Held bursts of nonzero values against idle gaps show whether edge mode counts transitions rather than active cycles. A configuration rewrite in the middle of a burst exposes whether the edge history is cleared. Random privilege levels against split OS/user settings check the privilege filter. Placing each restricted event code on both counters checks the slot rule. Presetting a counter just below the wrap point, with and without the interrupt enable, checks the carry, the sticky flag, the set-over-clear ordering and the interrupt timing.

// File: rtl/evc_pkg.sv
package evc_pkg;

  localparam int NUM_CTR = 2;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 3;

  // configuration word, bit 31 down to bit 0
  typedef struct packed {
    logic [1:0] rsv;
    logic       en;
    logic       ie;
    logic       usr;
    logic       os;
    logic       edg;
    logic       inv;
    logic [7:0] thr;
    logic [7:0] umask;
    logic [7:0] code;
  } evc_cfg_t;

  // some event codes are bound to a single counter slot
  function automatic logic evc_slot_ok(input logic [7:0] code, input int idx);
    logic ok;
    ok = 1'b1;
    if ((code == 8'h14 || code == 8'hC1) && idx != 0) ok = 1'b0;
    if ((code == 8'h13 || code == 8'h11) && idx != 1) ok = 1'b0;
    return ok;
  endfunction

endpackage

// File: rtl/evc_lane_sel.sv
module evc_lane_sel #(
  parameter int LANES = 16,
  parameter int EV_W  = 2
) (
  input  logic [LANES*EV_W-1:0] ev_bus,
  input  logic [7:0]            code,
  input  logic [7:0]            umask,
  output logic [EV_W-1:0]       ev_cnt
);
  localparam int LANE_BITS = (LANES > 1) ? $clog2(LANES) : 1;

  logic [9:0]           idx_full;
  logic [LANE_BITS-1:0] idx;

  assign idx_full = {umask, code[1:0]};
  assign idx      = idx_full[LANE_BITS-1:0];

  always_comb begin
    ev_cnt = '0;
    for (int k = 0; k < LANES; k++) begin
      if (idx == LANE_BITS'(k)) ev_cnt = ev_bus[k*EV_W +: EV_W];
    end
  end
endmodule

// File: rtl/evc_qual.sv
module evc_qual
  import evc_pkg::*;
#(
  parameter int EV_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  evc_cfg_t        cfg,
  input  logic [EV_W-1:0] ev_cnt,
  input  logic [1:0]      priv,
  input  logic            slot_ok,
  input  logic            cfg_wr,
  output logic [EV_W-1:0] inc
);
  logic       priv_ok, allowed, hit, cond, prev_q;
  logic [7:0] cnt_ext;

  assign cnt_ext = 8'(ev_cnt);
  assign priv_ok = (priv == 2'd0) ? cfg.os : cfg.usr;
  assign allowed = cfg.en & slot_ok & priv_ok;

  always_comb begin
    if (cfg.thr == 8'd0) hit = (ev_cnt != '0);
    else if (cfg.inv)    hit = (cnt_ext < cfg.thr);
    else                 hit = (cnt_ext >= cfg.thr);
  end

  assign cond = allowed & hit;

  always_ff @(posedge clk) begin
    if (rst || cfg_wr) prev_q <= 1'b0;
    else               prev_q <= cond;
  end

  always_comb begin
    if (!allowed)               inc = '0;
    else if (cfg.edg)           inc = EV_W'(cond & ~prev_q);
    else if (cfg.thr == 8'd0)   inc = ev_cnt;
    else                        inc = EV_W'(cond);
  end

  // R5
  edge_once_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg.edg && inc != '0 && !cfg_wr) |=> (inc == '0));

  // R7
  slot_block_chk: assert property (@(posedge clk) disable iff (rst)
    !slot_ok |-> (inc == '0));

  // R6
  os_filter_chk: assert property (@(posedge clk) disable iff (rst)
    (priv == 2'd0 && !cfg.os) |-> (inc == '0));

  // R3
  thr_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (!cfg.edg && !cfg.inv && cfg.thr != 8'd0 && cnt_ext < cfg.thr) |-> (inc == '0));
endmodule

// File: rtl/evc_ctr.sv
module evc_ctr #(
  parameter int CNT_W = 40,
  parameter int EV_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EV_W-1:0]  inc,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [31:0]      wdata,
  input  logic             clr_ovf,
  output logic [CNT_W-1:0] value,
  output logic             ovf
);
  localparam int HI_W = CNT_W - 32;

  logic [CNT_W:0] sum;
  logic           wr_any;

  assign sum    = {1'b0, value} + (CNT_W+1)'(inc);
  assign wr_any = wr_lo | wr_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
      ovf   <= 1'b0;
    end else begin
      if (wr_any) begin
        if (wr_lo) value[31:0]       <= wdata;
        if (wr_hi) value[CNT_W-1:32] <= wdata[HI_W-1:0];
      end else begin
        value <= sum[CNT_W-1:0];
      end
      ovf <= (ovf & ~clr_ovf) | (~wr_any & sum[CNT_W]);
    end
  end

  // R8
  wr_prio_chk: assert property (@(posedge clk) disable iff (rst)
    wr_lo |=> (value[31:0] == $past(wdata)));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf && !clr_ovf) |=> ovf);
endmodule

// File: rtl/evc_unit.sv
module evc_unit
  import evc_pkg::*;
#(
  parameter int LANES = 16,
  parameter int EV_W  = 2,
  parameter int CNT_W = 40
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LANES*EV_W-1:0] ev_bus,
  input  logic [1:0]            priv,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  output logic                  irq
);
  localparam int HI_W = CNT_W - 32;
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(2 + 2*NUM_CTR);

  evc_cfg_t             cfg_q [NUM_CTR];
  logic [CNT_W-1:0]     cnt   [NUM_CTR];
  logic [NUM_CTR-1:0]   ovf, ie_vec;
  logic [REG_W-1:0]     rd_mux;
  logic                 irq_q;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic [EV_W-1:0] ev_cnt, inc;
    logic            cfg_wr, wr_lo, wr_hi, clr;

    assign cfg_wr = reg_we && reg_addr == ADDR_W'(i);
    assign wr_lo  = reg_we && reg_addr == ADDR_W'(2 + 2*i);
    assign wr_hi  = reg_we && reg_addr == ADDR_W'(3 + 2*i);
    assign clr    = reg_we && reg_addr == STAT_ADDR && reg_wdata[i];
    assign ie_vec[i] = cfg_q[i].ie;

    always_ff @(posedge clk) begin
      if (rst)         cfg_q[i] <= '0;
      else if (cfg_wr) cfg_q[i] <= evc_cfg_t'(reg_wdata);
    end

    evc_lane_sel #(.LANES(LANES), .EV_W(EV_W)) u_sel (
      .ev_bus(ev_bus), .code(cfg_q[i].code), .umask(cfg_q[i].umask), .ev_cnt(ev_cnt)
    );

    evc_qual #(.EV_W(EV_W)) u_qual (
      .clk(clk), .rst(rst), .cfg(cfg_q[i]), .ev_cnt(ev_cnt), .priv(priv),
      .slot_ok(evc_slot_ok(cfg_q[i].code, i)), .cfg_wr(cfg_wr), .inc(inc)
    );

    evc_ctr #(.CNT_W(CNT_W), .EV_W(EV_W)) u_ctr (
      .clk(clk), .rst(rst), .inc(inc), .wr_lo(wr_lo), .wr_hi(wr_hi),
      .wdata(reg_wdata), .clr_ovf(clr), .value(cnt[i]), .ovf(ovf[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (reg_addr == ADDR_W'(i))       rd_mux = REG_W'(cfg_q[i]);
      if (reg_addr == ADDR_W'(2 + 2*i)) rd_mux = cnt[i][31:0];
      if (reg_addr == ADDR_W'(3 + 2*i)) rd_mux = REG_W'(cnt[i][CNT_W-1:32]);
    end
    if (reg_addr == STAT_ADDR) rd_mux = REG_W'(ovf);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_q     <= 1'b0;
    end else begin
      reg_rdata <= rd_mux;
      irq_q     <= |(ovf & ie_vec);
    end
  end

  assign irq = irq_q;

  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(ovf & ie_vec)));

  // R12
  rd_stat_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == STAT_ADDR) |=> (reg_rdata == REG_W'($past(ovf))));
endmodule

// File: tb/tb_evc_unit.sv
module tb_evc_unit;
  localparam int CLK_PERIOD = 10;
  localparam longint unsigned CMAX = 64'h10000000000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ev_bus = '0;
  logic [1:0]  priv = '0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0, fails = 0, cycles = 0, rot = 0;
  string cur_req = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evc_unit dut (
    .clk(clk), .rst(rst), .ev_bus(ev_bus), .priv(priv), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // behavioural reference state
  longint unsigned mc [2];
  bit [31:0]       mcfg [2];
  bit              mo [2];
  bit              mp [2];
  bit [31:0]       exp_rd = 0;
  bit              exp_irq = 0;
  bit              started = 0;

  function automatic int model_inc(input int i, input bit [31:0] bus, input int pr,
                                   output bit cnd);
    bit [31:0] c;
    int lane, v, thr;
    bit ok, h;
    c    = mcfg[i];
    lane = ((c[15:8] & 3) << 2) | (c[7:0] & 3);
    v    = (bus >> (2*lane)) & 3;
    thr  = c[23:16];
    ok   = c[29] && ((pr == 0) ? c[26] : c[27]);
    if ((c[7:0] == 8'h14 || c[7:0] == 8'hC1) && i != 0) ok = 0;
    if ((c[7:0] == 8'h13 || c[7:0] == 8'h11) && i != 1) ok = 0;
    if (thr == 0)  h = (v != 0);
    else if (c[24]) h = (v < thr);
    else            h = (v >= thr);
    cnd = ok && h;
    if (!ok) return 0;
    if (c[25]) return (cnd && !mp[i]) ? 1 : 0;
    if (thr == 0) return v;
    return cnd ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    int  incs [2];
    bit  cnds [2];
    started = 1;
    if (rst) begin
      for (int i = 0; i < 2; i++) begin mc[i] = 0; mcfg[i] = 0; mo[i] = 0; mp[i] = 0; end
      exp_rd = 0; exp_irq = 0;
    end else begin
      exp_irq = (mo[0] && mcfg[0][28]) || (mo[1] && mcfg[1][28]);
      case (reg_addr)
        3'd0: exp_rd = mcfg[0];
        3'd1: exp_rd = mcfg[1];
        3'd2: exp_rd = mc[0][31:0];
        3'd3: exp_rd = {24'd0, mc[0][39:32]};
        3'd4: exp_rd = mc[1][31:0];
        3'd5: exp_rd = {24'd0, mc[1][39:32]};
        3'd6: exp_rd = {30'd0, mo[1], mo[0]};
        default: exp_rd = 0;
      endcase
      for (int i = 0; i < 2; i++) incs[i] = model_inc(i, ev_bus, priv, cnds[i]);
      for (int i = 0; i < 2; i++) begin
        bit wlo, whi, setb, clr;
        longint unsigned t;
        wlo = reg_we && reg_addr == 3'(2 + 2*i);
        whi = reg_we && reg_addr == 3'(3 + 2*i);
        setb = 0;
        if (wlo || whi) begin
          if (wlo) mc[i] = (mc[i] & 64'hFF_0000_0000) | reg_wdata;
          if (whi) mc[i] = (mc[i] & 64'hFFFF_FFFF) | (longint'(reg_wdata & 32'hFF) << 32);
        end else begin
          t = mc[i] + incs[i];
          setb = (t >= CMAX);
          mc[i] = t % CMAX;
        end
        clr = reg_we && reg_addr == 3'd6 && reg_wdata[i];
        mo[i] = (mo[i] && !clr) || setb;
        if (reg_we && reg_addr == 3'(i)) begin mcfg[i] = reg_wdata; mp[i] = 0; end
        else mp[i] = cnds[i];
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (started && !done) begin
      checks++;
      if (reg_rdata !== exp_rd || irq !== exp_irq) begin
        fails++;
        $display("FAIL %s rdata=%h expected=%h irq=%b expected=%b", cur_req,
                 reg_rdata, exp_rd, irq, exp_irq);
      end
    end
    if (cycles > 100000 && !done) begin
      fails++;
      done = 1;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic cyc(input bit [31:0] bus, input bit [1:0] pr);
    @(negedge clk);
    ev_bus = bus; priv = pr; reg_we = 0; reg_addr = 3'(rot);
    rot = (rot + 1) % 7;
  endtask

  task automatic wr(input bit [2:0] a, input bit [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
  endtask

  task automatic rnd(input int n, input bit rp);
    for (int k = 0; k < n; k++) cyc($urandom, rp ? 2'($urandom) : 2'd0);
  endtask

  // cfg word: en 29, ie 28, usr 27, os 26, edge 25, inv 24, thr 23:16, umask 15:8, code 7:0
  function automatic bit [31:0] mk(bit ie, bit usr, bit os, bit edg, bit inv,
                                   bit [7:0] thr, bit [7:0] um, bit [7:0] code);
    return {2'b00, 1'b1, ie, usr, os, edg, inv, thr, um, code};
  endfunction

  initial begin
    cur_req = "R1";
    repeat (3) cyc(32'hFFFF_FFFF, 0);
    rst = 0;
    rnd(8, 0);

    cur_req = "R2";
    wr(0, mk(0,1,1,0,0,8'd0,8'h01,8'h02));
    wr(1, mk(0,1,1,0,0,8'd0,8'h02,8'h21));
    rnd(40, 0);

    cur_req = "R12";
    for (int a = 0; a < 8; a++) begin
      @(negedge clk); reg_we = 0; reg_addr = 3'(a); ev_bus = $urandom;
    end
    wr(7, 32'h1234_5678);
    rnd(8, 0);

    cur_req = "R3";
    wr(0, mk(0,1,1,0,0,8'd2,8'h03,8'h03));
    rnd(40, 0);

    cur_req = "R4";
    wr(1, mk(0,1,1,0,1,8'd2,8'h00,8'h01));
    rnd(30, 0);
    wr(1, mk(0,1,1,0,1,8'd0,8'h00,8'h01));
    rnd(20, 0);

    cur_req = "R5";
    wr(0, mk(0,1,1,1,0,8'd0,8'h00,8'h00));
    wr(1, mk(0,1,1,1,0,8'd3,8'h00,8'h00));
    for (int b = 0; b < 6; b++) begin
      repeat (5) cyc(32'hFFFF_FFFF, 0);
      repeat (3) cyc(32'h0, 0);
    end
    rnd(30, 0);

    cur_req = "R11";
    repeat (4) cyc(32'hFFFF_FFFF, 0);
    wr(0, mk(0,1,1,1,0,8'd0,8'h00,8'h00));
    repeat (6) cyc(32'hFFFF_FFFF, 0);

    cur_req = "R6";
    wr(0, mk(0,0,1,0,0,8'd0,8'h00,8'h02));
    wr(1, mk(0,1,0,0,0,8'd0,8'h00,8'h02));
    rnd(60, 1);

    cur_req = "R7";
    wr(0, mk(0,1,1,0,0,8'd0,8'h00,8'h13));
    wr(1, mk(0,1,1,0,0,8'd0,8'h00,8'h14));
    rnd(20, 0);
    wr(0, mk(0,1,1,0,0,8'd0,8'h00,8'hC1));
    wr(1, mk(0,1,1,0,0,8'd0,8'h00,8'h11));
    rnd(20, 0);
    wr(0, mk(0,1,1,0,0,8'd0,8'h00,8'h14));
    wr(1, mk(0,1,1,0,0,8'd0,8'h00,8'h13));
    rnd(20, 0);

    cur_req = "R8";
    wr(2, 32'hDEAD_BEEF);
    cyc(32'hFFFF_FFFF, 0);
    wr(5, 32'h0000_00A5);
    wr(4, 32'h0000_0010);
    rnd(15, 0);

    cur_req = "R9";
    wr(0, mk(1,1,1,0,0,8'd0,8'h00,8'h00));
    wr(1, mk(0,1,1,0,0,8'd0,8'h00,8'h00));
    wr(3, 32'hFF); wr(2, 32'hFFFF_FFFD);
    wr(5, 32'hFF); wr(4, 32'hFFFF_FFFC);
    repeat (10) cyc(32'hFFFF_FFFF, 0);
    wr(6, 32'h1);
    repeat (4) cyc(32'h0, 0);
    wr(3, 32'hFF); wr(2, 32'hFFFF_FFFF);
    wr(6, 32'h3);
    repeat (4) cyc(32'h0, 0);

    cur_req = "R10";
    wr(6, 32'h3);
    wr(3, 32'hFF); wr(2, 32'hFFFF_FFFE);
    repeat (6) cyc(32'hFFFF_FFFF, 0);
    wr(0, mk(0,1,1,0,0,8'd0,8'h00,8'h00));
    repeat (4) cyc(32'h0, 0);
    wr(0, mk(1,1,1,0,0,8'd0,8'h00,8'h00));
    repeat (4) cyc(32'h0, 0);
    wr(6, 32'h1);
    repeat (6) cyc(32'h0, 0);

    cur_req = "R2";
    rnd(40, 1);

    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule